// File: doc/BRIEF.md
# LIN-capable UART receiver with in-frame break recognition

This block receives 8-bit serial characters framed by one low start bit and one high stop bit, least significant bit first. It takes its timing from an oversampling strobe with `OSR` strobes per bit time, and samples each bit once, near the middle of the bit. Good characters go into a one-byte receive holding register, which a read strobe releases. Status flags report framing errors, overruns and successfully received break fields. Each flag has its own write-one-to-clear bit. A one-cycle status interrupt fires whenever an event sets a flag.

The two-bit mode input chooses what happens when the stop bit samples low. In the in-frame-break mode (`2'b10`) the receiver does not judge the character at the stop bit. It keeps counting the current run of consecutive low samples until the line samples high again. A run shorter than `BRK_BITS` bit times is a damaged character. A run of `BRK_BITS` or more is a break field, even if the break began partway through the data bits. In every other mode a low stop bit is a framing error straight away. Software can also arm a break-wait state. While this state is set, the receiver decodes no characters and only looks for a long low run.

Top module: `lin_rx_brk`

## Requirements
- R1: After reset, rx_data is 0x00, and rx_full, err_frame, err_overrun, brk_seen, brk_wait and irq are all 0.
- R2: A character whose stop bit samples high is stored in rx_data (first received bit into bit 0) and sets rx_full, provided rx_full was clear.
- R3: If a character completes while rx_full is set and no read strobe is given in that cycle, err_overrun is set and rx_data keeps the older byte.
- R4: In mode 2'b10 with a low stop bit, nothing is reported at the stop sample. At the first later high sample, a low run shorter than BRK_BITS stores the byte and sets err_frame if rx_full was clear. If rx_full was set, it sets err_overrun only. brk_seen is not set.
- R5: A run of at least BRK_BITS consecutive low samples (default 11), ended by a high sample, sets brk_seen and stores no byte. This holds whether the run starts at the start bit or partway through the data bits.
- R6: In any mode other than 2'b10, a low stop bit sets err_frame at the stop sample and stores no byte. The receiver then waits for a high sample before it accepts a new start bit.
- R7: A brk_arm pulse sets brk_wait. While brk_wait is set, characters are neither stored nor flagged. A detected break sets brk_seen and clears brk_wait.
- R8: irq is high for exactly the one cycle after any event that sets err_frame, err_overrun or brk_seen.
- R9: clr_w1c bit 0 clears err_frame, bit 1 clears err_overrun and bit 2 clears brk_seen. A set event in the same cycle takes priority.
- R10: rd_strobe clears rx_full.
- R11: The start bit is sampled on the (OSR/2)th os_tick after the falling edge, and each later bit OSR os_ticks after the previous one. Cycles without os_tick do not advance sampling.
- R12: A low pulse that has ended before the start-bit sample point is discarded, with no change to any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rxd | input | 1 | Serial receive line, idle high, synchronous to clk |
| os_tick | input | 1 | Oversampling strobe, OSR per bit time |
| mode | input | 2 | 2'b10 selects in-frame break recognition |
| brk_arm | input | 1 | Pulse that enters the break-wait state |
| rd_strobe | input | 1 | Read of the receive register, clears rx_full |
| clr_w1c | input | 3 | Write-one-to-clear for {brk_seen, err_overrun, err_frame} |
| rx_data | output | 8 | Receive holding register |
| rx_full | output | 1 | Unread byte present |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Overrun error flag |
| brk_seen | output | 1 | Break field received flag |
| brk_wait | output | 1 | Break-wait state active |
| irq | output | 1 | One-cycle status interrupt |

## Verification
Several properties are checked on every cycle. The framer reports at most one event per cycle. Sample points are never back to back. The long-low state is entered only in mode 2'b10. An overrun or a break never changes the holding register. The interrupt never fires without a flag behind it. A detected break always drops the wait state. Which event a particular waveform produces is shown only by the bench's scenarios, which compare against a behavioural model on every clock. These scenarios are: the ten-low versus eleven-low boundary, a break that starts in the middle of the data bits, a low stop bit with and without a pending byte, characters sent while armed, short glitches and a half-rate strobe.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FRAME  = 3'd1,
    ST_RUN    = 3'd2,
    ST_WAITHI = 3'd3,
    ST_BRKM   = 3'd4
  } rx_state_e;

  localparam logic [1:0] MODE_INFRAME_BRK = 2'b10;

  typedef struct packed {
    logic byte_done;
    logic bad_stop;
    logic fe_only;
    logic brk;
  } rx_evt_t;

endpackage

// File: rtl/lin_rx_tick.sv
module lin_rx_tick #(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic os_tick_i,
  input  logic restart_i,
  output logic samp_o
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i) begin
      cnt_d = '0;
    end else if (os_tick_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign samp_o = os_tick_i && !restart_i && (cnt_q == MID);

  AST_SAMPLE_GAP: assert property (@(posedge clk) disable iff (!rst_ni)
    samp_o |=> !samp_o) else $error("sample points adjacent"); // R11

endmodule

// File: rtl/lin_rx_fsm.sv
module lin_rx_fsm
  import lin_rx_pkg::*;
#(
  parameter int BRK_BITS = 11
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       rxd_i,
  input  logic       samp_i,
  input  logic [1:0] mode_i,
  input  logic       wait_i,
  output logic       restart_o,
  output rx_evt_t    evt_o,
  output logic [7:0] data_o
);

  localparam int RW = $clog2(BRK_BITS + 1);
  localparam logic [RW-1:0] BRK_C = RW'(BRK_BITS);
  localparam logic [3:0] STOP_IDX = 4'd9;

  rx_state_e     st_q, st_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic [RW-1:0] run_q, run_d, run_inc;
  logic          rxd_q;
  logic          brk_hit;

  assign run_inc = (run_q == BRK_C) ? run_q : run_q + 1'b1;
  assign brk_hit = (run_q >= BRK_C);

  always_comb begin
    st_d      = st_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    run_d     = run_q;
    restart_o = 1'b0;
    evt_o     = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (rxd_q && !rxd_i) begin
          restart_o = 1'b1;
          run_d     = '0;
          bit_d     = '0;
          st_d      = wait_i ? ST_BRKM : ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (samp_i) begin
          if (bit_q == 4'd0) begin
            if (rxd_i) begin
              st_d = ST_IDLE;
            end else begin
              run_d = run_inc;
              bit_d = 4'd1;
            end
          end else if (bit_q < STOP_IDX) begin
            sh_d  = {rxd_i, sh_q[7:1]};
            run_d = rxd_i ? '0 : run_inc;
            bit_d = bit_q + 4'd1;
          end else if (rxd_i) begin
            evt_o.byte_done = 1'b1;
            st_d            = ST_IDLE;
          end else if (mode_i == MODE_INFRAME_BRK) begin
            run_d = run_inc;
            st_d  = ST_RUN;
          end else begin
            evt_o.fe_only = 1'b1;
            st_d          = ST_WAITHI;
          end
        end
      end
      ST_RUN: begin
        if (samp_i) begin
          if (!rxd_i) begin
            run_d = run_inc;
          end else begin
            if (brk_hit) begin
              evt_o.brk = 1'b1;
            end else begin
              evt_o.byte_done = 1'b1;
              evt_o.bad_stop  = 1'b1;
            end
            st_d = ST_IDLE;
          end
        end
      end
      ST_WAITHI: begin
        if (samp_i && rxd_i) st_d = ST_IDLE;
      end
      ST_BRKM: begin
        if (samp_i) begin
          if (!rxd_i) begin
            run_d = run_inc;
          end else begin
            evt_o.brk = brk_hit;
            st_d      = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      sh_q  <= '0;
      run_q <= '0;
      rxd_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      run_q <= run_d;
      rxd_q <= rxd_i;
    end
  end

  assign data_o = sh_q;

  AST_RUN_ONLY_INFRAME: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(st_q == ST_RUN) |-> $past(mode_i) == MODE_INFRAME_BRK) else $error("long-low state in wrong mode"); // R6

  AST_WAIT_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_BRKM) |-> !evt_o.byte_done && !evt_o.fe_only) else $error("character reported while armed"); // R7

endmodule

// File: rtl/lin_rx_stat.sv
module lin_rx_stat
  import lin_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  rx_evt_t    evt_i,
  input  logic [7:0] data_i,
  input  logic       rd_i,
  input  logic [2:0] clr_i,
  input  logic       arm_i,
  output logic [7:0] rx_data_o,
  output logic       full_o,
  output logic       fe_o,
  output logic       ovr_o,
  output logic       brk_o,
  output logic       wait_o,
  output logic       irq_o
);

  logic [7:0] data_q, data_d;
  logic       full_q, full_d, fe_q, fe_d, ovr_q, ovr_d, brk_q, brk_d;
  logic       wait_q, wait_d, irq_q, irq_d;
  logic       full_eff, store, set_fe, set_ovr, set_brk;

  always_comb begin
    full_eff = full_q & ~rd_i;
    store    = evt_i.byte_done & ~full_eff;
    set_ovr  = evt_i.byte_done & full_eff;
    set_fe   = (store & evt_i.bad_stop) | evt_i.fe_only;
    set_brk  = evt_i.brk;
    data_d   = store ? data_i : data_q;
    full_d   = store | full_eff;
    fe_d     = set_fe  | (fe_q  & ~clr_i[0]);
    ovr_d    = set_ovr | (ovr_q & ~clr_i[1]);
    brk_d    = set_brk | (brk_q & ~clr_i[2]);
    wait_d   = arm_i   | (wait_q & ~evt_i.brk);
    irq_d    = set_fe | set_ovr | set_brk;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      fe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      brk_q  <= 1'b0;
      wait_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      fe_q   <= fe_d;
      ovr_q  <= ovr_d;
      brk_q  <= brk_d;
      wait_q <= wait_d;
      irq_q  <= irq_d;
    end
  end

  assign rx_data_o = data_q;
  assign full_o    = full_q;
  assign fe_o      = fe_q;
  assign ovr_o     = ovr_q;
  assign brk_o     = brk_q;
  assign wait_o    = wait_q;
  assign irq_o     = irq_q;

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_i.byte_done && full_q && !rd_i) |=> $stable(rx_data_o)) else $error("overrun replaced data"); // R3

  AST_BRK_NO_DATA: assert property (@(posedge clk) disable iff (!rst_ni)
    evt_i.brk |=> $stable(rx_data_o)) else $error("break stored a byte"); // R5

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> (fe_q || ovr_q || brk_q)) else $error("interrupt without flag"); // R8

  AST_BRK_DROPS_WAIT: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_i.brk && !arm_i) |=> !wait_o) else $error("wait kept after break"); // R7

endmodule

// File: rtl/lin_rx_brk.sv
module lin_rx_brk
  import lin_rx_pkg::*;
#(
  parameter int OSR      = 8,
  parameter int BRK_BITS = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       os_tick,
  input  logic [1:0] mode,
  input  logic       brk_arm,
  input  logic       rd_strobe,
  input  logic [2:0] clr_w1c,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       brk_seen,
  output logic       brk_wait,
  output logic       irq
);

  logic [1:0] rs_q;
  logic       rst_ni;
  logic       restart, samp;
  rx_evt_t    evt;
  logic [7:0] shift_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  lin_rx_tick #(.OSR(OSR)) u_tick (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .os_tick_i (os_tick),
    .restart_i (restart),
    .samp_o    (samp)
  );

  lin_rx_fsm #(.BRK_BITS(BRK_BITS)) u_fsm (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .rxd_i     (rxd),
    .samp_i    (samp),
    .mode_i    (mode),
    .wait_i    (brk_wait),
    .restart_o (restart),
    .evt_o     (evt),
    .data_o    (shift_data)
  );

  lin_rx_stat u_stat (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .data_i    (shift_data),
    .rd_i      (rd_strobe),
    .clr_i     (clr_w1c),
    .arm_i     (brk_arm),
    .rx_data_o (rx_data),
    .full_o    (rx_full),
    .fe_o      (err_frame),
    .ovr_o     (err_overrun),
    .brk_o     (brk_seen),
    .wait_o    (brk_wait),
    .irq_o     (irq)
  );

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({evt.byte_done, evt.fe_only, evt.brk})) else $error("simultaneous events"); // R4

endmodule

// File: tb/sim_lin_rx_brk.sv
module sim_lin_rx_brk;
  localparam int CLK_PERIOD = 10;
  localparam int OSR = 8;
  localparam int BRK = 11;

  logic       clk = 1'b0;
  logic       rst_n, rxd, os_tick, brk_arm, rd_strobe;
  logic [1:0] mode;
  logic [2:0] clr_w1c;
  logic [7:0] rx_data;
  logic       rx_full, err_frame, err_overrun, brk_seen, brk_wait, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int tick_div = 1;
  string cur_req = "R1";

  // behavioural reference state
  int m_st, m_cnt, m_bit, m_run;
  logic [7:0] m_sh;
  bit m_rxq, m_s1, m_s2;
  logic [7:0] e_data;
  bit e_full, e_fe, e_ovr, e_brk, e_wait, e_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_rx_brk #(.OSR(OSR), .BRK_BITS(BRK)) u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick), .mode(mode),
    .brk_arm(brk_arm), .rd_strobe(rd_strobe), .clr_w1c(clr_w1c),
    .rx_data(rx_data), .rx_full(rx_full), .err_frame(err_frame),
    .err_overrun(err_overrun), .brk_seen(brk_seen), .brk_wait(brk_wait), .irq(irq)
  );

  task automatic model_clear();
    m_st = 0; m_cnt = 0; m_bit = 0; m_run = 0; m_sh = 8'h00; m_rxq = 1;
    e_data = 8'h00; e_full = 0; e_fe = 0; e_ovr = 0; e_brk = 0; e_wait = 0; e_irq = 0;
  endtask

  task automatic model_edge();
    bit restart, samp, ev_b, ev_bad, ev_fe, ev_brk, full_eff, store, s_fe, s_ov;
    int nst, inc;
    if (!rst_n) begin model_clear(); m_s1 = 0; m_s2 = 0; return; end
    if (!m_s2) begin m_s2 = m_s1; m_s1 = 1; return; end
    m_s2 = m_s1; m_s1 = 1;
    restart = (m_st == 0) && m_rxq && !rxd;
    samp = os_tick && !restart && (m_cnt == OSR/2 - 1);
    ev_b = 0; ev_bad = 0; ev_fe = 0; ev_brk = 0; nst = m_st;
    inc = (m_run >= BRK) ? BRK : m_run + 1;
    case (m_st)
      0: if (restart) begin m_run = 0; m_bit = 0; nst = e_wait ? 4 : 1; end
      1: if (samp) begin
           if (m_bit == 0) begin
             if (rxd) nst = 0; else begin m_run = inc; m_bit = 1; end
           end else if (m_bit < 9) begin
             m_sh = {rxd, m_sh[7:1]}; m_run = rxd ? 0 : inc; m_bit++;
           end else if (rxd) begin ev_b = 1; nst = 0; end
           else if (mode == 2'b10) begin m_run = inc; nst = 2; end
           else begin ev_fe = 1; nst = 3; end
         end
      2: if (samp) begin
           if (!rxd) m_run = inc;
           else begin
             if (m_run >= BRK) ev_brk = 1; else begin ev_b = 1; ev_bad = 1; end
             nst = 0;
           end
         end
      3: if (samp && rxd) nst = 0;
      4: if (samp) begin
           if (!rxd) m_run = inc; else begin ev_brk = (m_run >= BRK); nst = 0; end
         end
      default: nst = 0;
    endcase
    full_eff = e_full && !rd_strobe;
    store = ev_b && !full_eff;
    s_ov = ev_b && full_eff;
    s_fe = (store && ev_bad) || ev_fe;
    if (store) e_data = m_sh;
    e_full = store || full_eff;
    e_fe = s_fe || (e_fe && !clr_w1c[0]);
    e_ovr = s_ov || (e_ovr && !clr_w1c[1]);
    e_brk = ev_brk || (e_brk && !clr_w1c[2]);
    e_wait = brk_arm || (e_wait && !ev_brk);
    e_irq = s_fe || s_ov || ev_brk;
    if (restart) m_cnt = 0;
    else if (os_tick) m_cnt = (m_cnt == OSR - 1) ? 0 : m_cnt + 1;
    m_rxq = rxd;
    m_st = nst;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ok;
    ok = (rx_data === e_data) && (rx_full === e_full) && (err_frame === e_fe) &&
         (err_overrun === e_ovr) && (brk_seen === e_brk) && (brk_wait === e_wait) && (irq === e_irq);
    chk(ok, cur_req, "outputs {data,full,fe,ovr,brk,wait,irq}",
        {rx_data, rx_full, err_frame, err_overrun, brk_seen, brk_wait, irq},
        {e_data, e_full, e_fe, e_ovr, e_brk, e_wait, e_irq});
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    os_tick = (tick_div == 2) ? !os_tick : 1'b1;
  endtask

  task automatic send_bit(input bit v);
    rxd = v;
    repeat (OSR * tick_div) step();
  endtask

  task automatic frame(input logic [7:0] d, input bit stop_hi, input int extra_low, input int idle_bits);
    send_bit(0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(stop_hi);
    repeat (extra_low) send_bit(0);
    repeat (idle_bits) send_bit(1);
  endtask

  task automatic pulse_rd();  rd_strobe = 1; step(); rd_strobe = 0; endtask
  task automatic pulse_clr(input logic [2:0] c); clr_w1c = c; step(); clr_w1c = 3'b000; endtask
  task automatic pulse_arm(); brk_arm = 1; step(); brk_arm = 0; endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rxd = 1; os_tick = 1; mode = 2'b00; brk_arm = 0; rd_strobe = 0; clr_w1c = 3'b000;
    model_clear(); m_s1 = 0; m_s2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) step();
    // R1 reset state
    cur_req = "R1";
    chk(rx_data == 8'h00 && !rx_full && !err_frame && !err_overrun && !brk_seen && !brk_wait && !irq,
        "R1", "reset outputs", {rx_data, rx_full, irq}, 0);

    // R2 good character, R10 read
    cur_req = "R2";
    frame(8'hA5, 1, 0, 2);
    chk(rx_data == 8'hA5 && rx_full, "R2", "stored byte", rx_data, 8'hA5);
    cur_req = "R10";
    pulse_rd();
    chk(!rx_full, "R10", "full after read", rx_full, 0);

    // R3 overrun keeps old byte, R9 clear
    cur_req = "R3";
    frame(8'h3C, 1, 0, 2);
    frame(8'h81, 1, 0, 2);
    chk(err_overrun && rx_data == 8'h3C, "R3", "overrun data", rx_data, 8'h3C);
    cur_req = "R9";
    pulse_clr(3'b010);
    chk(!err_overrun, "R9", "overrun cleared", err_overrun, 0);
    pulse_rd();

    // R6 low stop bit in plain mode
    cur_req = "R6";
    frame(8'h77, 0, 0, 2);
    chk(err_frame && !rx_full && rx_data == 8'h3C, "R6", "plain-mode stop low", {err_frame, rx_full}, 2);
    pulse_clr(3'b001);

    // R12 glitch rejected
    cur_req = "R12";
    rxd = 0; step(); step();
    send_bit(1); send_bit(1);
    chk(!rx_full && !err_frame && !brk_seen, "R12", "glitch ignored", rx_full, 0);

    // R4 in-frame mode: short low run
    cur_req = "R4";
    mode = 2'b10;
    frame(8'h5A, 0, 0, 2);
    chk(err_frame && rx_full && rx_data == 8'h5A && !brk_seen, "R4", "short run stores", rx_data, 8'h5A);
    pulse_clr(3'b001);
    frame(8'h00, 0, 0, 2);
    chk(err_overrun && !err_frame && rx_data == 8'h5A, "R4", "short run while full", {err_overrun, err_frame}, 2);
    pulse_clr(3'b011);
    pulse_rd();
    frame(8'h00, 0, 0, 2);
    chk(err_frame && rx_data == 8'h00 && !brk_seen, "R4", "ten lows is not break", rx_data, 0);
    pulse_clr(3'b001);
    pulse_rd();

    // R5 break at eleven lows, and starting mid-character
    cur_req = "R5";
    frame(8'h00, 0, 1, 2);
    chk(brk_seen && !rx_full && !err_frame, "R5", "eleven lows", brk_seen, 1);
    pulse_clr(3'b100);
    frame(8'h0F, 0, 6, 2);
    chk(brk_seen && !rx_full && rx_data == 8'h00, "R5", "break inside character", brk_seen, 1);
    pulse_clr(3'b100);

    // R7 break-wait
    cur_req = "R7";
    mode = 2'b00;
    pulse_arm();
    chk(brk_wait, "R7", "armed", brk_wait, 1);
    frame(8'h55, 1, 0, 2);
    chk(!rx_full && !err_frame && brk_wait, "R7", "character ignored while armed", rx_full, 0);
    frame(8'h00, 0, 1, 2);
    chk(brk_seen && !brk_wait && !rx_full, "R7", "break ends wait", {brk_seen, brk_wait}, 2);

    // R9 set wins over clear in same cycle (via per-cycle model) and R8 pulse seen
    cur_req = "R8";
    pulse_clr(3'b111);
    frame(8'h12, 0, 0, 1);
    chk(err_frame, "R8", "flag after event", err_frame, 1);
    pulse_clr(3'b001);

    // R11 half-rate oversampling strobe
    cur_req = "R11";
    tick_div = 2;
    frame(8'hC3, 1, 0, 2);
    tick_div = 1; os_tick = 1;
    chk(rx_full && rx_data == 8'hC3, "R11", "half-rate strobe", rx_data, 8'hC3);
    pulse_rd();
    repeat (4) step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule